// File: doc/BRIEF.md
# Pipelined RAM Read Output Stage

This block is a single-port synchronous RAM. Its read path can have zero, one or two register stages after the array's output latch. With two stages, read data passes from the latch to an inner register and then to a final register that drives the port. The output reset and the optional register clock-enable act only on the final stage. This lets the user decide, cycle by cycle, which read words reach the output, without stalling the stages in front of it.

The number of stages, the value the output is forced to, the read-during-write order and the use of a separate register clock-enable are all fixed when the block is elaborated. When the clock-enable option is off, the port enable takes its place for the final stage. The reset is synchronous and has no effect on the array contents.

Top module: `rdpipe_ram`

## Requirements
- R1: With `en` and `reg_ce` held high, the word read at a clock edge appears on `rd_data` after 1 + OUT_STAGES edges. Consecutive reads come out in issue order, one per cycle.
- R2: When `out_rst` and the final-stage gate are both high at an edge, `rd_data` becomes RST_VAL after that edge. Stages in front of the final stage keep flowing, so the following addresses still come out in order.
- R3: With USE_REGCE=1 and `reg_ce` low, `out_rst` has no effect. `rd_data` keeps its value.
- R4: With USE_REGCE=1 and `reg_ce` low, the final stage holds while `en` high keeps the earlier stages advancing. When `reg_ce` returns high, the word taken is the one the inner stage holds at that time.
- R5: With USE_REGCE=0, the final stage advances and resets on `en`, and `reg_ce` is ignored. With `en` low, `out_rst` does nothing. RST_VAL defaults to all zeros.
- R6: With OUT_STAGES=0, a reset forces the array output latch itself to RST_VAL. That read word is replaced, and the next read appears on the following edge.
- R7: With `en` low, no write happens, the latch and the inner register hold, and the array contents stay unchanged.
- R8: On a read of the address being written, WRITE_FIRST=1 returns the new data and WRITE_FIRST=0 returns the previously stored data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all activity on the rising edge |
| en | input | 1 | Port enable for array access and the inner stage |
| wr_en | input | 1 | Write request, acted on only with `en` |
| addr | input | ADDR_W | Word address |
| wr_data | input | DATA_W | Data to write |
| out_rst | input | 1 | Synchronous reset of the final stage only |
| reg_ce | input | 1 | Final-stage clock-enable (used when USE_REGCE=1) |
| rd_data | output | DATA_W | Read data from the final stage |

## Verification
The final stage can receive a reset request and a capture request in the same cycle. The bench drives `out_rst` high together with the gate, and again with the gate low, in the middle of a stream of back-to-back reads. In the first case it expects exactly one word to be replaced by RST_VAL and the next address to follow in sequence. In the second case it expects the output to hold. A second collision is a read of the address being written. The same stimulus is sent to a read-first and a write-first instance, and each is judged against its own ordering.

// File: rtl/rdpipe_pkg.sv
package rdpipe_pkg;
  // Enable that clocks the final stage
  function automatic logic final_gate(input bit use_ce, input logic ce, input logic en);
    return use_ce ? ce : en;
  endfunction

  // Edges from a read request to its appearance on the output
  function automatic int unsigned read_latency(input int unsigned stages);
    return 1 + stages;
  endfunction
endpackage

// File: rtl/rdpipe_array.sv
module rdpipe_array #(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned ADDR_W      = 6,
  parameter bit          WRITE_FIRST = 1'b0,
  parameter logic [DATA_W-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rst_hit,
  output logic [DATA_W-1:0] q
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_word;

  assign rd_word = (WRITE_FIRST && we) ? wdata : mem[addr];

  always_ff @(posedge clk) begin
    if (en && we) mem[addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst_hit)  q <= RST_VAL;
    else if (en)  q <= rd_word;
  end
endmodule

// File: rtl/rdpipe_stage.sv
module rdpipe_stage #(
  parameter int unsigned DATA_W = 16,
  parameter logic [DATA_W-1:0] RST_VAL = '0
) (
  input  logic              clk,
  input  logic              adv,
  input  logic              rst_hit,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst_hit)  q <= RST_VAL;
    else if (adv) q <= d;
  end
endmodule

// File: rtl/rdpipe_ram.sv
module rdpipe_ram #(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned ADDR_W      = 6,
  parameter int unsigned OUT_STAGES  = 2,
  parameter logic [DATA_W-1:0] RST_VAL = '0,
  parameter bit          USE_REGCE   = 1'b1,
  parameter bit          WRITE_FIRST = 1'b0
) (
  input  logic              clk,
  input  logic              en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              out_rst,
  input  logic              reg_ce,
  output logic [DATA_W-1:0] rd_data
);
  localparam bool_latch_last = (OUT_STAGES == 0);

  // Named internal events for the checker
  logic              final_load;
  logic              final_rst;
  logic [DATA_W-1:0] latch_q;
  logic [DATA_W-1:0] pre_final;

  assign final_load = rdpipe_pkg::final_gate(USE_REGCE, reg_ce, en);
  assign final_rst  = out_rst && final_load;

  rdpipe_array #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .WRITE_FIRST(WRITE_FIRST), .RST_VAL(RST_VAL)
  ) u_array (
    .clk(clk), .en(en), .we(wr_en), .addr(addr), .wdata(wr_data),
    .rst_hit(bool_latch_last ? final_rst : 1'b0),
    .q(latch_q)
  );

  generate
    if (OUT_STAGES == 0) begin : g_none
      assign pre_final = latch_q;
      assign rd_data   = latch_q;
    end else if (OUT_STAGES == 1) begin : g_one
      assign pre_final = latch_q;
      rdpipe_stage #(.DATA_W(DATA_W), .RST_VAL(RST_VAL)) u_final (
        .clk(clk), .adv(final_load), .rst_hit(final_rst),
        .d(latch_q), .q(rd_data)
      );
    end else begin : g_two
      logic [DATA_W-1:0] inner_q;
      rdpipe_stage #(.DATA_W(DATA_W), .RST_VAL(RST_VAL)) u_inner (
        .clk(clk), .adv(en), .rst_hit(1'b0),
        .d(latch_q), .q(inner_q)
      );
      assign pre_final = inner_q;
      rdpipe_stage #(.DATA_W(DATA_W), .RST_VAL(RST_VAL)) u_final (
        .clk(clk), .adv(final_load), .rst_hit(final_rst),
        .d(inner_q), .q(rd_data)
      );
    end
  endgenerate
endmodule

// File: rtl/rdpipe_ram_chk.sv
module rdpipe_ram_chk #(
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned OUT_STAGES = 2,
  parameter logic [DATA_W-1:0] RST_VAL = '0
) (
  input logic              clk,
  input logic              en,
  input logic              final_load,
  input logic              final_rst,
  input logic [DATA_W-1:0] latch_q,
  input logic [DATA_W-1:0] pre_final,
  input logic [DATA_W-1:0] rd_data
);
  logic started = 1'b0;
  always_ff @(posedge clk) started <= 1'b1;

  // R2
  final_rst_val_chk: assert property (@(posedge clk) disable iff (!started)
    final_rst |=> (rd_data == RST_VAL));

  // R3 R4
  final_hold_chk: assert property (@(posedge clk) disable iff (!started)
    (!final_load && (OUT_STAGES != 0 || !en)) |=> $stable(rd_data));

  // R1
  final_take_chk: assert property (@(posedge clk) disable iff (!started)
    (final_load && !final_rst && OUT_STAGES != 0) |=> (rd_data == $past(pre_final)));

  // R7
  latch_hold_chk: assert property (@(posedge clk) disable iff (!started)
    (!en && !final_rst) |=> $stable(latch_q));
endmodule

bind rdpipe_ram rdpipe_ram_chk #(
  .DATA_W(DATA_W), .OUT_STAGES(OUT_STAGES), .RST_VAL(RST_VAL)
) u_chk (
  .clk(clk), .en(en), .final_load(final_load), .final_rst(final_rst),
  .latch_q(latch_q), .pre_final(pre_final), .rd_data(rd_data)
);

// File: tb/tb_rdpipe_ram.sv
module tb_rdpipe_ram;
  localparam int DW = 16;
  localparam int AW = 6;
  localparam int NC = 4;
  localparam int CS [NC] = '{2, 1, 0, 1};
  localparam bit CU [NC] = '{1'b1, 1'b1, 1'b1, 1'b0};
  localparam bit CW [NC] = '{1'b0, 1'b1, 1'b0, 1'b0};
  localparam logic [DW-1:0] CR [NC] = '{16'hFFFF, 16'h5A5A, 16'h0F0F, 16'h0000};

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic en = 0, we = 0, rst = 0, ce = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wd = '0;
  logic [DW-1:0] q [NC];

  rdpipe_ram #(.DATA_W(DW), .ADDR_W(AW), .OUT_STAGES(2), .RST_VAL(16'hFFFF),
    .USE_REGCE(1'b1), .WRITE_FIRST(1'b0)) dut (
    .clk(clk), .en(en), .wr_en(we), .addr(addr), .wr_data(wd),
    .out_rst(rst), .reg_ce(ce), .rd_data(q[0]));
  rdpipe_ram #(.DATA_W(DW), .ADDR_W(AW), .OUT_STAGES(1), .RST_VAL(16'h5A5A),
    .USE_REGCE(1'b1), .WRITE_FIRST(1'b1)) dut_s1 (
    .clk(clk), .en(en), .wr_en(we), .addr(addr), .wr_data(wd),
    .out_rst(rst), .reg_ce(ce), .rd_data(q[1]));
  rdpipe_ram #(.DATA_W(DW), .ADDR_W(AW), .OUT_STAGES(0), .RST_VAL(16'h0F0F),
    .USE_REGCE(1'b1), .WRITE_FIRST(1'b0)) dut_s0 (
    .clk(clk), .en(en), .wr_en(we), .addr(addr), .wr_data(wd),
    .out_rst(rst), .reg_ce(ce), .rd_data(q[2]));
  rdpipe_ram #(.DATA_W(DW), .ADDR_W(AW), .OUT_STAGES(1),
    .USE_REGCE(1'b0), .WRITE_FIRST(1'b0)) dut_nc (
    .clk(clk), .en(en), .wr_en(we), .addr(addr), .wr_data(wd),
    .out_rst(rst), .reg_ce(ce), .rd_data(q[3]));

  typedef struct {
    logic [DW-1:0] exp [NC];
    string         tag;
  } item_t;
  item_t sb [$];

  logic [DW-1:0] ref_mem [1 << AW];
  logic [DW-1:0] m_lat [NC];
  logic [DW-1:0] m_in  [NC];
  logic [DW-1:0] m_out [NC];
  int checks = 0, fails = 0;
  bit done = 0;

  function automatic logic [DW-1:0] pat(input int a);
    return 16'h3C00 ^ DW'(a * 16'h0111);
  endfunction

  // Driver: set inputs, advance the expected pipeline, push one item per edge
  task automatic step(input logic e, input logic w, input int a, input logic [DW-1:0] d,
                      input logic r, input logic c, input string tag);
    item_t it;
    @(negedge clk);
    en = e; we = w; addr = AW'(a); wd = d; rst = r; ce = c;
    for (int k = 0; k < NC; k++) begin
      logic g, hit;
      logic [DW-1:0] rd, nl, np, no;
      g   = CU[k] ? c : e;
      hit = r && g;
      rd  = (CW[k] && w) ? d : ref_mem[AW'(a)];
      nl  = e ? rd : m_lat[k];
      np  = m_in[k];
      no  = m_out[k];
      if (CS[k] == 0) begin
        if (hit) nl = CR[k];
      end else if (CS[k] == 1) begin
        no = hit ? CR[k] : (g ? m_lat[k] : m_out[k]);
      end else begin
        np = e ? m_lat[k] : m_in[k];
        no = hit ? CR[k] : (g ? m_in[k] : m_out[k]);
      end
      m_lat[k] = nl; m_in[k] = np; m_out[k] = no;
      it.exp[k] = (CS[k] == 0) ? nl : no;
    end
    if (e && w) ref_mem[AW'(a)] = d;
    it.tag = tag;
    sb.push_back(it);
  endtask

  // Monitor: compare each instance after the edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() != 0) begin
        item_t it;
        it = sb.pop_front();
        for (int k = 0; k < NC; k++) begin
          if (!$isunknown(it.exp[k])) begin
            checks++;
            if (q[k] !== it.exp[k]) begin
              fails++;
              $display("FAIL %s inst%0d actual=%h expected=%h", it.tag, k, q[k], it.exp[k]);
            end
          end
        end
      end
    end
  end

  initial begin
    #1500000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // Reset state: every instance to its own value (R2, R5 default zero, R6)
    for (int i = 0; i < 3; i++) step(1, 0, 0, '0, 1, 1, "R2_reset_state");
    // Fill the array; the write-first instance shows written data (R8)
    for (int a = 0; a < 16; a++) step(1, 1, a, pat(a), 0, 1, "R8_fill");
    // Streaming reads, latency per configuration (R1)
    for (int a = 0; a < 16; a++) step(1, 0, a, '0, 0, 1, "R1_stream");
    // Single reset pulse inside a stream (R2, R6)
    for (int a = 0; a < 8; a++) step(1, 0, a, '0, a == 4, 1, "R2_pulse");
    for (int a = 8; a < 12; a++) step(1, 0, a, '0, 0, 1, "R6_after_pulse");
    // Reset with clock-enable low is ignored; final stage holds (R3, R4)
    step(1, 0, 3, '0, 1, 0, "R3_rst_no_ce");
    step(1, 0, 5, '0, 0, 0, "R4_hold");
    step(1, 0, 7, '0, 0, 1, "R4_resume");
    step(1, 0, 9, '0, 0, 1, "R4_resume");
    step(1, 0, 2, '0, 0, 1, "R4_resume");
    // Enable low: no write, everything holds; enable-gated instance ignores reset (R7, R5)
    step(0, 1, 6, 16'hDEAD, 0, 0, "R7_en_low_write");
    step(0, 0, 1, '0, 1, 0, "R5_rst_en_low");
    step(0, 0, 1, '0, 0, 1, "R5_ce_ignored");
    step(1, 0, 6, '0, 0, 1, "R7_readback");
    step(1, 0, 6, '0, 0, 1, "R7_readback");
    step(1, 0, 6, '0, 0, 1, "R7_readback");
    // Read during write of same address (R8)
    step(1, 1, 10, 16'hBEEF, 0, 1, "R8_collide");
    step(1, 0, 10, '0, 0, 1, "R8_collide");
    step(1, 0, 11, '0, 0, 1, "R8_collide");
    step(1, 0, 12, '0, 0, 1, "R8_collide");
    // Enable-gated reset on the no-clock-enable instance (R5)
    step(1, 0, 13, '0, 1, 0, "R5_rst_with_en");
    step(1, 0, 14, '0, 0, 0, "R5_ce_ignored");
    for (int a = 0; a < 4; a++) step(1, 0, a, '0, 0, 1, "R1_drain");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule